// File: doc/BRIEF.md
# Out-of-Order Read Line Reassembler

This block sits between a memory response channel and a consumer that needs whole requests in order. A read of one, two or four lines is opened on a tag slot before its data returns. The channel may then deliver that request's lines in any order. Each line carries the full request tag, a 2-bit position within the request and a 512-bit payload. The block files every line under the slot named by the low tag bits. When all positions of a request are present, it streams the request out, position 0 first, marked with start and end flags.

A second, smaller table counts write completions. A multi-line write can be acknowledged one line at a time, in any order. The block reports the write finished only after every acknowledgement for that tag has arrived.

The response input cannot be back-pressured: a line is taken whenever `rsp_valid` is high. The output is a valid/ready stream. Once `out_valid` is high, the tag, position, flags and data stay unchanged until a cycle in which `out_ready` is also high. A request is never interleaved with another on the output. The slot stays occupied until the consumer takes its final line.

Top module: `rd_reassembler`

## Requirements
- R1: After reset `out_valid`, `rsp_err` and `wr_done_valid` are low and every slot is free.
- R2: `rd_alloc_ok` is high in the same cycle as `rd_alloc_valid` when slot `rd_alloc_tag[3:0]` is free and the length code is legal. Length codes: 0 = one line, 1 = two lines, 3 = four lines. An accepted request takes effect at that clock edge.
- R3: A request on a slot that is still occupied is refused (`rd_alloc_ok` low). A slot becomes free in the cycle after the handshake of its final output line.
- R4: Length code 2 is refused for both reads and writes.
- R5: Once complete, a request is emitted with `out_idx` counting from 0 up to its line count minus one. Each line carries the data received for that position and `out_tag` equal to the full opening tag, whatever order the lines arrived in.
- R6: `out_first` is high only on position 0 and `out_last` only on the final position. A one-line request has both flags high on its single line.
- R7: While `out_valid` is high and `out_ready` is low, the output tag, position, flags and data hold unchanged.
- R8: A line whose position has already arrived for its open request is discarded. The output keeps the first copy, and `rsp_err` is high for one cycle after the offending line.
- R9: A line whose slot is free, whose full tag differs from the open tag, or whose position is at or beyond the request length is discarded. `rsp_err` is high for one cycle after it, and the line affects neither data nor release.
- R10: No line of a request appears on the output before all of its positions have arrived.
- R11: A write opened with `wr_start_valid` (refused on an occupied slot or with length code 2) completes after exactly as many `wr_cpl_valid` beats carrying its full tag as it has lines. `wr_done_valid` then pulses for one cycle, on the cycle after the final completion, with `wr_done_tag`. Completions for a free slot or a different tag are ignored.
- R12: When several requests are complete, each is emitted whole before the next begins, and the lowest slot number goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_alloc_valid | input | 1 | Open a read request |
| rd_alloc_tag | input | 8 | Tag of the read being opened |
| rd_alloc_len | input | 2 | Length code of the read |
| rd_alloc_ok | output | 1 | Open accepted this cycle |
| rsp_valid | input | 1 | Response line present |
| rsp_tag | input | 8 | Tag of the response line |
| rsp_idx | input | 2 | Position of the line in its request |
| rsp_data | input | 512 | Line payload |
| rsp_err | output | 1 | Previous response line was discarded |
| out_valid | output | 1 | Output line available |
| out_ready | input | 1 | Consumer takes the line |
| out_tag | output | 8 | Tag of the output request |
| out_idx | output | 2 | Position of the output line |
| out_first | output | 1 | First line of a request |
| out_last | output | 1 | Final line of a request |
| out_data | output | 512 | Output payload |
| wr_start_valid | input | 1 | Open a write for counting |
| wr_start_tag | input | 8 | Tag of the write |
| wr_start_len | input | 2 | Length code of the write |
| wr_start_ok | output | 1 | Write open accepted this cycle |
| wr_cpl_valid | input | 1 | One write completion |
| wr_cpl_tag | input | 8 | Tag of the completion |
| wr_done_valid | output | 1 | A write has fully completed |
| wr_done_tag | output | 8 | Tag of the completed write |

## Verification
The cycle-level assertions cover the stream rules on every cycle. Output stays frozen under stall. Positions advance by one within a tag. A new request begins with its start flag. Accepts never occur for the reserved length. Every error or write-done pulse traces back to an input beat in the preceding cycle. The directed scenarios are needed for the rest: out-of-order and duplicate lines rebuilt into correct data, withheld release until the last position, slot refusal and reuse, lowest-slot priority across several finished requests, and exact completion counting.

// File: rtl/rra_pkg.sv
package rra_pkg;
  localparam int IDX_W     = 2;
  localparam int MAX_LINES = 4;

  typedef enum logic [1:0] {
    LEN_ONE  = 2'd0,
    LEN_TWO  = 2'd1,
    LEN_RSV  = 2'd2,
    LEN_FOUR = 2'd3
  } len_code_e;

  function automatic logic len_legal(input logic [1:0] code);
    return code != LEN_RSV;
  endfunction

  function automatic logic [MAX_LINES-1:0] full_mask(input logic [1:0] code);
    case (code)
      LEN_ONE:  return 4'b0001;
      LEN_TWO:  return 4'b0011;
      LEN_FOUR: return 4'b1111;
      default:  return 4'b0000;
    endcase
  endfunction

  function automatic logic [2:0] line_count(input logic [1:0] code);
    case (code)
      LEN_ONE:  return 3'd1;
      LEN_TWO:  return 3'd2;
      LEN_FOUR: return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/rra_slot_table.sv
module rra_slot_table
  import rra_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic [1:0]        alloc_len,
  output logic              alloc_ok,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [IDX_W-1:0]  rsp_idx,
  output logic              line_good,
  output logic              line_bad,
  input  logic              free_en,
  input  logic [SLOT_W-1:0] free_slot,
  output logic [(1<<SLOT_W)-1:0] slot_done,
  output logic [1:0]        slot_len [1<<SLOT_W],
  output logic [TAG_W-1:0]  slot_tag [1<<SLOT_W]
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [SLOT_W-1:0] a_slot;
  logic [SLOT_W-1:0] r_slot;
  logic [SLOTS-1:0]  busy_w;
  logic [SLOTS-1:0]  good_w;

  assign a_slot    = alloc_tag[SLOT_W-1:0];
  assign r_slot    = rsp_tag[SLOT_W-1:0];
  assign alloc_ok  = alloc_valid && !busy_w[a_slot] && len_legal(alloc_len);
  assign line_good = |good_w;
  assign line_bad  = rsp_valid && !line_good;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic                 busy_r;
    logic [1:0]           len_r;
    logic [TAG_W-1:0]     tag_r;
    logic [MAX_LINES-1:0] mask_r;
    logic                 take_here;

    assign take_here = rsp_valid && (r_slot == SLOT_W'(g)) && busy_r &&
                       (tag_r == rsp_tag) && (rsp_idx <= len_r) && !mask_r[rsp_idx];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_r <= 1'b0;
        len_r  <= 2'd0;
        tag_r  <= '0;
        mask_r <= '0;
      end else if (alloc_ok && (a_slot == SLOT_W'(g))) begin
        busy_r <= 1'b1;
        len_r  <= alloc_len;
        tag_r  <= alloc_tag;
        mask_r <= '0;
      end else begin
        if (take_here) mask_r[rsp_idx] <= 1'b1;
        if (free_en && (free_slot == SLOT_W'(g))) busy_r <= 1'b0;
      end
    end

    assign busy_w[g]    = busy_r;
    assign good_w[g]    = take_here;
    assign slot_done[g] = busy_r && (mask_r == full_mask(len_r));
    assign slot_len[g]  = len_r;
    assign slot_tag[g]  = tag_r;
  end
endmodule

// File: rtl/rra_line_store.sv
module rra_line_store
  import rra_pkg::*;
#(
  parameter int SLOT_W = 4,
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              we,
  input  logic [SLOT_W-1:0] wslot,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0] rslot,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = (1 << SLOT_W) * MAX_LINES;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[{wslot, widx}] <= wdata;
  end

  assign rdata = mem[{rslot, ridx}];
endmodule

// File: rtl/rra_out_sched.sv
module rra_out_sched
  import rra_pkg::*;
#(
  parameter int SLOT_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [(1<<SLOT_W)-1:0] slot_done,
  input  logic [1:0]             cur_len,
  input  logic                   out_ready,
  output logic                   active,
  output logic [SLOT_W-1:0]      cur_slot,
  output logic [IDX_W-1:0]       cur_idx,
  output logic                   is_first,
  output logic                   is_last,
  output logic                   free_en
);
  localparam int SLOTS = 1 << SLOT_W;

  logic              pick_any;
  logic [SLOT_W-1:0] pick_slot;
  logic              fire;

  always_comb begin
    pick_any  = 1'b0;
    pick_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (slot_done[i]) begin
        pick_any  = 1'b1;
        pick_slot = SLOT_W'(i);
      end
    end
  end

  assign is_first = (cur_idx == '0);
  assign is_last  = (cur_idx == cur_len);
  assign fire     = active && out_ready;
  assign free_en  = fire && is_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_slot <= '0;
      cur_idx  <= '0;
    end else if (!active) begin
      if (pick_any) begin
        active   <= 1'b1;
        cur_slot <= pick_slot;
        cur_idx  <= '0;
      end
    end else if (fire) begin
      if (is_last) active  <= 1'b0;
      else         cur_idx <= cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/rra_wr_tracker.sv
module rra_wr_tracker
  import rra_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int SLOT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  input  logic [TAG_W-1:0] start_tag,
  input  logic [1:0]       start_len,
  output logic             start_ok,
  input  logic             cpl_valid,
  input  logic [TAG_W-1:0] cpl_tag,
  output logic             done_valid,
  output logic [TAG_W-1:0] done_tag
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [SLOTS-1:0] busy_w;
  logic [SLOTS-1:0] fin_w;
  logic [SLOT_W-1:0] s_slot;

  assign s_slot   = start_tag[SLOT_W-1:0];
  assign start_ok = start_valid && !busy_w[s_slot] && len_legal(start_len);

  for (genvar g = 0; g < SLOTS; g++) begin : g_wslot
    logic             busy_r;
    logic [TAG_W-1:0] tag_r;
    logic [2:0]       rem_r;
    logic             cpl_here;

    assign cpl_here = cpl_valid && busy_r && (tag_r == cpl_tag);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_r <= 1'b0;
        tag_r  <= '0;
        rem_r  <= '0;
      end else if (start_ok && (s_slot == SLOT_W'(g))) begin
        busy_r <= 1'b1;
        tag_r  <= start_tag;
        rem_r  <= line_count(start_len);
      end else if (cpl_here) begin
        rem_r <= rem_r - 3'd1;
        if (rem_r == 3'd1) busy_r <= 1'b0;
      end
    end

    assign busy_w[g] = busy_r;
    assign fin_w[g]  = cpl_here && (rem_r == 3'd1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_valid <= 1'b0;
      done_tag   <= '0;
    end else begin
      done_valid <= |fin_w;
      done_tag   <= cpl_tag;
    end
  end
endmodule

// File: rtl/rd_reassembler.sv
module rd_reassembler
  import rra_pkg::*;
#(
  parameter int TAG_W  = 8,
  parameter int SLOT_W = 4,
  parameter int DATA_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_alloc_valid,
  input  logic [TAG_W-1:0]  rd_alloc_tag,
  input  logic [1:0]        rd_alloc_len,
  output logic              rd_alloc_ok,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [1:0]        rsp_idx,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TAG_W-1:0]  out_tag,
  output logic [1:0]        out_idx,
  output logic              out_first,
  output logic              out_last,
  output logic [DATA_W-1:0] out_data,
  input  logic              wr_start_valid,
  input  logic [TAG_W-1:0]  wr_start_tag,
  input  logic [1:0]        wr_start_len,
  output logic              wr_start_ok,
  input  logic              wr_cpl_valid,
  input  logic [TAG_W-1:0]  wr_cpl_tag,
  output logic              wr_done_valid,
  output logic [TAG_W-1:0]  wr_done_tag
);
  localparam int SLOTS = 1 << SLOT_W;

  logic              line_good;
  logic              line_bad;
  logic              free_en;
  logic [SLOTS-1:0]  slot_done;
  logic [1:0]        slot_len [SLOTS];
  logic [TAG_W-1:0]  slot_tag [SLOTS];
  logic              active;
  logic [SLOT_W-1:0] cur_slot;
  logic [IDX_W-1:0]  cur_idx;

  rra_slot_table #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(rd_alloc_valid), .alloc_tag(rd_alloc_tag),
    .alloc_len(rd_alloc_len), .alloc_ok(rd_alloc_ok),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_idx(rsp_idx),
    .line_good(line_good), .line_bad(line_bad),
    .free_en(free_en), .free_slot(cur_slot),
    .slot_done(slot_done), .slot_len(slot_len), .slot_tag(slot_tag)
  );

  rra_line_store #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(line_good),
    .wslot(rsp_tag[SLOT_W-1:0]), .widx(rsp_idx), .wdata(rsp_data),
    .rslot(cur_slot), .ridx(cur_idx), .rdata(out_data)
  );

  rra_out_sched #(.SLOT_W(SLOT_W)) u_sched (
    .clk(clk), .rst_n(rst_n),
    .slot_done(slot_done), .cur_len(slot_len[cur_slot]),
    .out_ready(out_ready), .active(active),
    .cur_slot(cur_slot), .cur_idx(cur_idx),
    .is_first(out_first), .is_last(out_last), .free_en(free_en)
  );

  rra_wr_tracker #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .start_valid(wr_start_valid), .start_tag(wr_start_tag),
    .start_len(wr_start_len), .start_ok(wr_start_ok),
    .cpl_valid(wr_cpl_valid), .cpl_tag(wr_cpl_tag),
    .done_valid(wr_done_valid), .done_tag(wr_done_tag)
  );

  assign out_valid = active;
  assign out_tag   = slot_tag[cur_slot];
  assign out_idx   = cur_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) rsp_err <= 1'b0;
    else        rsp_err <= line_bad;
  end
endmodule

// File: rtl/rra_checks.sv
module rra_checks #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_alloc_valid,
  input logic [1:0]        rd_alloc_len,
  input logic              rd_alloc_ok,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              out_valid,
  input logic              out_ready,
  input logic [TAG_W-1:0]  out_tag,
  input logic [1:0]        out_idx,
  input logic              out_first,
  input logic              out_last,
  input logic [DATA_W-1:0] out_data,
  input logic              wr_start_valid,
  input logic [1:0]        wr_start_len,
  input logic              wr_start_ok,
  input logic              wr_cpl_valid,
  input logic [TAG_W-1:0]  wr_cpl_tag,
  input logic              wr_done_valid,
  input logic [TAG_W-1:0]  wr_done_tag
);
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag) &&
    $stable(out_idx) && $stable(out_first) && $stable(out_last)); // R7

  AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && !out_first &&
    (out_idx == $past(out_idx) + 2'd1) && $stable(out_tag)); // R5

  AST_NEXT_REQ_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid || out_first); // R6

  AST_RD_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_alloc_ok |-> rd_alloc_valid && rd_alloc_len != 2'd2); // R4

  AST_WR_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start_ok |-> wr_start_valid && wr_start_len != 2'd2); // R4

  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(rsp_valid)); // R8

  AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_valid |-> $past(wr_cpl_valid) && wr_done_tag == $past(wr_cpl_tag)); // R11
endmodule

bind rd_reassembler rra_checks #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_alloc_valid(rd_alloc_valid), .rd_alloc_len(rd_alloc_len), .rd_alloc_ok(rd_alloc_ok),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag), .out_idx(out_idx),
  .out_first(out_first), .out_last(out_last), .out_data(out_data),
  .wr_start_valid(wr_start_valid), .wr_start_len(wr_start_len), .wr_start_ok(wr_start_ok),
  .wr_cpl_valid(wr_cpl_valid), .wr_cpl_tag(wr_cpl_tag),
  .wr_done_valid(wr_done_valid), .wr_done_tag(wr_done_tag)
);

// File: tb/sim_rd_reassembler.sv
module sim_rd_reassembler;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rd_alloc_valid = 1'b0;
  logic [7:0]   rd_alloc_tag = '0;
  logic [1:0]   rd_alloc_len = '0;
  logic         rd_alloc_ok;
  logic         rsp_valid = 1'b0;
  logic [7:0]   rsp_tag = '0;
  logic [1:0]   rsp_idx = '0;
  logic [511:0] rsp_data = '0;
  logic         rsp_err;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [7:0]   out_tag;
  logic [1:0]   out_idx;
  logic         out_first;
  logic         out_last;
  logic [511:0] out_data;
  logic         wr_start_valid = 1'b0;
  logic [7:0]   wr_start_tag = '0;
  logic [1:0]   wr_start_len = '0;
  logic         wr_start_ok;
  logic         wr_cpl_valid = 1'b0;
  logic [7:0]   wr_cpl_tag = '0;
  logic         wr_done_valid;
  logic [7:0]   wr_done_tag;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rd_reassembler u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_alloc_valid(rd_alloc_valid), .rd_alloc_tag(rd_alloc_tag),
    .rd_alloc_len(rd_alloc_len), .rd_alloc_ok(rd_alloc_ok),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_idx(rsp_idx),
    .rsp_data(rsp_data), .rsp_err(rsp_err),
    .out_valid(out_valid), .out_ready(out_ready), .out_tag(out_tag),
    .out_idx(out_idx), .out_first(out_first), .out_last(out_last),
    .out_data(out_data),
    .wr_start_valid(wr_start_valid), .wr_start_tag(wr_start_tag),
    .wr_start_len(wr_start_len), .wr_start_ok(wr_start_ok),
    .wr_cpl_valid(wr_cpl_valid), .wr_cpl_tag(wr_cpl_tag),
    .wr_done_valid(wr_done_valid), .wr_done_tag(wr_done_tag)
  );

  function automatic logic [511:0] mkdata(input logic [7:0] tag, input logic [1:0] idx);
    return {16{8'hA5, tag, 14'h0, idx}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic alloc(input logic [7:0] tag, input logic [1:0] len, input bit exp_ok, input string req);
    @(negedge clk);
    rd_alloc_valid = 1'b1; rd_alloc_tag = tag; rd_alloc_len = len;
    #1;
    chk(rd_alloc_ok == exp_ok, req, 64'(rd_alloc_ok), 64'(exp_ok));
    @(negedge clk);
    rd_alloc_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] tag, input logic [1:0] idx, input logic [511:0] d,
                      input bit exp_err, input string req);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_tag = tag; rsp_idx = idx; rsp_data = d;
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(rsp_err == exp_err, req, 64'(rsp_err), 64'(exp_err));
  endtask

  task automatic drain(input logic [7:0] tag, input int n, input string req);
    int waited = 0;
    @(negedge clk);
    while (!out_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    for (int i = 0; i < n; i++) begin
      chk(out_valid == 1'b1, req, 64'(out_valid), 64'd1);
      chk(out_tag == tag, req, 64'(out_tag), 64'(tag));
      chk(out_idx == 2'(i), req, 64'(out_idx), 64'(i));
      chk(out_first == (i == 0), "R6", 64'(out_first), 64'(i == 0));
      chk(out_last == (i == n - 1), "R6", 64'(out_last), 64'(i == n - 1));
      chk(out_data == mkdata(tag, 2'(i)), req, out_data[63:0], mkdata(tag, 2'(i)) ~^ 64'h0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    chk(rsp_err == 1'b0, "R1", 64'(rsp_err), 64'd0);
    chk(wr_done_valid == 1'b0, "R1", 64'(wr_done_valid), 64'd0);
  endtask

  task automatic t_out_of_order();
    alloc(8'h15, 2'd3, 1'b1, "R2");
    send(8'h15, 2'd2, mkdata(8'h15, 2'd2), 1'b0, "R5");
    send(8'h15, 2'd0, mkdata(8'h15, 2'd0), 1'b0, "R5");
    send(8'h15, 2'd3, mkdata(8'h15, 2'd3), 1'b0, "R5");
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", 64'(out_valid), 64'd0);
    send(8'h15, 2'd1, mkdata(8'h15, 2'd1), 1'b0, "R5");
    drain(8'h15, 4, "R5");
  endtask

  task automatic t_single();
    alloc(8'h03, 2'd0, 1'b1, "R2");
    send(8'h03, 2'd0, mkdata(8'h03, 2'd0), 1'b0, "R6");
    drain(8'h03, 1, "R6");
  endtask

  task automatic t_busy_and_stall();
    logic [511:0] held;
    logic [1:0]   held_idx;
    alloc(8'h22, 2'd1, 1'b1, "R2");
    alloc(8'h32, 2'd1, 1'b0, "R3");
    send(8'h22, 2'd1, mkdata(8'h22, 2'd1), 1'b0, "R5");
    send(8'h22, 2'd0, mkdata(8'h22, 2'd0), 1'b0, "R5");
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b1, "R7", 64'(out_valid), 64'd1);
    held = out_data; held_idx = out_idx;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == held && out_idx == held_idx, "R7",
          out_data[63:0], held[63:0]);
    end
    alloc(8'h32, 2'd1, 1'b0, "R3");
    drain(8'h22, 2, "R5");
    alloc(8'h32, 2'd0, 1'b1, "R3");
    send(8'h32, 2'd0, mkdata(8'h32, 2'd0), 1'b0, "R5");
    drain(8'h32, 1, "R3");
  endtask

  task automatic t_bad_len();
    alloc(8'h07, 2'd2, 1'b0, "R4");
    alloc(8'h07, 2'd0, 1'b1, "R2");
    send(8'h07, 2'd0, mkdata(8'h07, 2'd0), 1'b0, "R5");
    drain(8'h07, 1, "R5");
  endtask

  task automatic t_duplicate();
    alloc(8'h44, 2'd1, 1'b1, "R2");
    send(8'h44, 2'd0, mkdata(8'h44, 2'd0), 1'b0, "R8");
    send(8'h44, 2'd0, ~mkdata(8'h44, 2'd0), 1'b1, "R8");
    send(8'h44, 2'd1, mkdata(8'h44, 2'd1), 1'b0, "R8");
    drain(8'h44, 2, "R8");
  endtask

  task automatic t_stray();
    send(8'h09, 2'd0, mkdata(8'h09, 2'd0), 1'b1, "R9");
    alloc(8'h19, 2'd1, 1'b1, "R2");
    send(8'h29, 2'd0, ~mkdata(8'h19, 2'd0), 1'b1, "R9");
    send(8'h19, 2'd2, mkdata(8'h19, 2'd2), 1'b1, "R9");
    send(8'h19, 2'd1, mkdata(8'h19, 2'd1), 1'b0, "R9");
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
    send(8'h19, 2'd0, mkdata(8'h19, 2'd0), 1'b0, "R9");
    drain(8'h19, 2, "R9");
  endtask

  task automatic t_priority();
    alloc(8'h01, 2'd0, 1'b1, "R2");
    alloc(8'h0A, 2'd1, 1'b1, "R2");
    alloc(8'h05, 2'd1, 1'b1, "R2");
    send(8'h01, 2'd0, mkdata(8'h01, 2'd0), 1'b0, "R12");
    send(8'h0A, 2'd1, mkdata(8'h0A, 2'd1), 1'b0, "R12");
    send(8'h0A, 2'd0, mkdata(8'h0A, 2'd0), 1'b0, "R12");
    send(8'h05, 2'd0, mkdata(8'h05, 2'd0), 1'b0, "R12");
    send(8'h05, 2'd1, mkdata(8'h05, 2'd1), 1'b0, "R12");
    drain(8'h01, 1, "R12");
    drain(8'h05, 2, "R12");
    drain(8'h0A, 2, "R12");
  endtask

  task automatic wstart(input logic [7:0] tag, input logic [1:0] len, input bit exp_ok);
    @(negedge clk);
    wr_start_valid = 1'b1; wr_start_tag = tag; wr_start_len = len;
    #1;
    chk(wr_start_ok == exp_ok, "R11", 64'(wr_start_ok), 64'(exp_ok));
    @(negedge clk);
    wr_start_valid = 1'b0;
  endtask

  task automatic wcpl(input logic [7:0] tag, input bit exp_done, input logic [7:0] exp_tag);
    @(negedge clk);
    wr_cpl_valid = 1'b1; wr_cpl_tag = tag;
    @(negedge clk);
    wr_cpl_valid = 1'b0;
    chk(wr_done_valid == exp_done, "R11", 64'(wr_done_valid), 64'(exp_done));
    if (exp_done) chk(wr_done_tag == exp_tag, "R11", 64'(wr_done_tag), 64'(exp_tag));
  endtask

  task automatic t_writes();
    wstart(8'h31, 2'd3, 1'b1);
    wstart(8'h41, 2'd0, 1'b0);
    wstart(8'h06, 2'd2, 1'b0);
    wcpl(8'h31, 1'b0, 8'h0);
    wcpl(8'h31, 1'b0, 8'h0);
    wcpl(8'h0F, 1'b0, 8'h0);
    wcpl(8'h21, 1'b0, 8'h0);
    wcpl(8'h31, 1'b0, 8'h0);
    wcpl(8'h31, 1'b1, 8'h31);
    @(negedge clk);
    chk(wr_done_valid == 1'b0, "R11", 64'(wr_done_valid), 64'd0);
    wstart(8'h41, 2'd0, 1'b1);
    wcpl(8'h41, 1'b1, 8'h41);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_out_of_order();
    t_single();
    t_busy_and_stall();
    t_bad_len();
    t_duplicate();
    t_stray();
    t_priority();
    t_writes();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule